// File: doc/BRIEF.md
# Special Register Write Filter with Field Lockout and Multiplier Warm-Up

This block sits on the write side of a special-register bus. Every write cycle carries an address, a data byte and a strobe. The block holds a small set of configuration registers. For most of them it stores the written byte after fixed bits have been forced to one or zero.

Two of the registers guard each other. A 2-bit mode field in the memory-configuration register and a single enable bit in the address-configuration register can never both be set. Whichever of the two is already set blocks the other.

A power-control write with a particular bit pattern requests the clock multiplier. On that write the block records a free-running tick value supplied from outside and clears a ready bit in the flag register. Once a fixed number of ticks has elapsed, it sets the ready bit again.

Top module: `sfr_wfilter`

## Requirements
- R1: After reset the registers read: address-configuration 0xF8, memory-configuration 0x10, pointer-select 0x04, timer-mode 0xE4, memory-count 0x2F, power-control 0x03, flag 0x00. The ready output is 0 and no warm-up is pending.
- R2: A write to the address-configuration register (default address 0x40) stores the data with bits 7:3 forced to one.
- R3: If memory-configuration bits 7:6 are both one, a write to address-configuration stores bit 2 as zero. Address-configuration bit 2 and memory-configuration bits 7:6 = 11 are never held at the same time.
- R4: A write to memory-configuration (default address 0x41) stores the data with bit 4 forced to one. If address-configuration bit 2 is set, that write also stores bits 7:6 as zero.
- R5: A write to pointer-select (default address 0x42) stores (data AND 0xE5) OR 0x04.
- R6: Writes to timer-mode (0x43), memory-count (0x44) and power-control (0x45) store the data OR 0xE0, OR 0x0F and OR 0x03 respectively.
- R7: A power-control write whose stored value, masked with 0xD0, equals 0x90 has two effects. It records the tick input of that cycle as the warm-up start, and it clears bit 3 (ready) of the flag register.
- R8: While a warm-up is pending, the first clock at which (tick − start) modulo 2^TICK_W is at least DELAY (default 65535) sets flag bit 3 and ends the pending state. A pending warm-up never sets the bit earlier.
- R9: A power-control write that does not match the R7 pattern cancels a pending warm-up, so the ready bit stays clear however many ticks pass.
- R10: The flag register (default address 0x46) stores written data unchanged. A write to an address outside the map changes no register.
- R11: Every register change appears at the outputs on the clock edge that samples the write, with no further latency. The `ready` output equals flag bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| tick | input | TICK_W | Free-running tick count |
| acfg_q | output | 8 | Address-configuration register |
| mcfg_q | output | 8 | Memory-configuration register |
| psel_q | output | 8 | Pointer-select register |
| t2m_q | output | 8 | Timer-mode register |
| mcnt_q | output | 8 | Memory-count register |
| pmgt_q | output | 8 | Power-control register |
| xflag_q | output | 8 | Flag register |
| ready | output | 1 | Multiplier ready (flag bit 3) |

## Verification
The hardest state to reach from the ports is the exact boundary of the 65535-tick warm-up window. The wrap of the tick counter during a pending warm-up is equally hard. The tick is an input, so the bench jumps it directly to start + 65534 and then to start + 65535. It also arms a request a few ticks below the counter's maximum and strides across the wrap. The lockout interplay is reached by writing the two guarded registers in both orders. Each order is followed by an attempt to set the blocked field.

// File: rtl/sfrf_pkg.sv
package sfrf_pkg;
   localparam int DW = 8;

   // Address-configuration register
   localparam logic [DW-1:0] ACFG_RST  = 8'hF8;
   localparam logic [DW-1:0] ACFG_OR   = 8'hF8;
   localparam int            ACFG_LOCK = 2;      // enable bit

   // Memory-configuration register
   localparam logic [DW-1:0] MCFG_RST  = 8'h10;
   localparam logic [DW-1:0] MCFG_OR   = 8'h10;
   localparam int            MCFG_MHI  = 7;      // mode field high bit
   localparam int            MCFG_MLO  = 6;      // mode field low bit

   // Power-control request pattern
   localparam logic [DW-1:0] PM_MASK   = 8'hD0;
   localparam logic [DW-1:0] PM_MATCH  = 8'h90;

   // Flag register
   localparam logic [DW-1:0] XF_RST    = 8'h00;
   localparam int            XF_RDY    = 3;

   // Plain masked registers: pointer-select, timer-mode, memory-count, power-control
   localparam int NMR = 4;

   typedef struct packed {
      logic [DW-1:0] rstv;
      logic [DW-1:0] andm;
      logic [DW-1:0] orm;
   } mreg_cfg_t;

   function automatic mreg_cfg_t mreg_cfg(input int idx);
      mreg_cfg_t c;
      case (idx)
         0:       c = '{rstv: 8'h04, andm: 8'hE5, orm: 8'h04};
         1:       c = '{rstv: 8'hE4, andm: 8'hFF, orm: 8'hE0};
         2:       c = '{rstv: 8'h2F, andm: 8'hFF, orm: 8'h0F};
         default: c = '{rstv: 8'h03, andm: 8'hFF, orm: 8'h03};
      endcase
      return c;
   endfunction

   function automatic logic [DW-1:0] filt(input logic [DW-1:0] d,
                                          input logic [DW-1:0] andm,
                                          input logic [DW-1:0] orm);
      return (d & andm) | orm;
   endfunction
endpackage

// File: rtl/sfrf_mreg.sv
module sfrf_mreg
   import sfrf_pkg::*;
#(
   parameter int            AW   = 8,
   parameter logic [AW-1:0] ADDR = '0,
   parameter logic [DW-1:0] RSTV = '0,
   parameter logic [DW-1:0] ANDM = '1,
   parameter logic [DW-1:0] ORM  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] q
);
   if ((RSTV & ORM) != ORM) begin : g_bad_rst
      $error("sfrf_mreg: reset value violates forced-one mask");
   end

   logic hit;
   assign hit = wr_en && (wr_addr == ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= RSTV;
      else if (hit) q <= filt(wr_data, ANDM, ORM);
   end

   a_r6_forced_bits: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (((q & ORM) == ORM) && ((q & ~ANDM) == '0)));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(q));
endmodule

// File: rtl/sfrf_lockout.sv
module sfrf_lockout
   import sfrf_pkg::*;
#(
   parameter int            AW     = 8,
   parameter logic [AW-1:0] A_ACFG = '0,
   parameter logic [AW-1:0] A_MCFG = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] acfg_q,
   output logic [DW-1:0] mcfg_q
);
   if (A_ACFG == A_MCFG) begin : g_bad_addr
      $error("sfrf_lockout: addresses collide");
   end

   logic          ac_hit, mc_hit, mode_on;
   logic [DW-1:0] ac_nx, mc_nx;

   assign ac_hit  = wr_en && (wr_addr == A_ACFG);
   assign mc_hit  = wr_en && (wr_addr == A_MCFG);
   assign mode_on = &mcfg_q[MCFG_MHI:MCFG_MLO];

   always_comb begin
      ac_nx = wr_data | ACFG_OR;
      if (mode_on) ac_nx[ACFG_LOCK] = 1'b0;
      mc_nx = wr_data | MCFG_OR;
      if (acfg_q[ACFG_LOCK]) mc_nx[MCFG_MHI:MCFG_MLO] = 2'b00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acfg_q <= ACFG_RST;
         mcfg_q <= MCFG_RST;
      end else begin
         if (ac_hit) acfg_q <= ac_nx;
         if (mc_hit) mcfg_q <= mc_nx;
      end
   end

   a_r2_acfg_upper: assert property (@(posedge clk) disable iff (!rst_n)
      ac_hit |=> (acfg_q[7:3] == 5'h1F));
   a_r3_lock_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ac_hit && mode_on) |=> !acfg_q[ACFG_LOCK]);
   a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(acfg_q[ACFG_LOCK] && (&mcfg_q[MCFG_MHI:MCFG_MLO])));
   a_r4_mcfg_bit4: assert property (@(posedge clk) disable iff (!rst_n)
      mc_hit |=> mcfg_q[4]);
   a_r4_lock_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_hit && acfg_q[ACFG_LOCK]) |=> (mcfg_q[MCFG_MHI:MCFG_MLO] == 2'b00));
endmodule

// File: rtl/sfrf_warmup.sv
module sfrf_warmup
   import sfrf_pkg::*;
#(
   parameter int TICK_W = 24,
   parameter int DELAY  = 65535
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pm_wr,
   input  logic [DW-1:0]     pm_val,
   input  logic              xf_wr,
   input  logic [DW-1:0]     xf_data,
   input  logic [TICK_W-1:0] tick,
   output logic [DW-1:0]     xflag_q,
   output logic              armed_q
);
   localparam logic [TICK_W-1:0] DLY = TICK_W'(DELAY);

   if (TICK_W < 2 || TICK_W > 32) begin : g_bad_w
      $error("sfrf_warmup: TICK_W out of range");
   end
   if (DELAY < 1 || longint'(DELAY) >= (longint'(1) << TICK_W)) begin : g_bad_d
      $error("sfrf_warmup: DELAY does not fit the tick width");
   end

   logic [TICK_W-1:0] start_q, elapsed;
   logic              match, expire;
   logic [DW-1:0]     xf_nx;

   assign match   = (pm_val & PM_MASK) == PM_MATCH;
   assign elapsed = tick - start_q;
   assign expire  = armed_q && !pm_wr && (elapsed >= DLY);

   always_comb begin
      xf_nx = xf_wr ? xf_data : xflag_q;
      if (pm_wr && match) xf_nx[XF_RDY] = 1'b0;
      else if (expire)    xf_nx[XF_RDY] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xflag_q <= XF_RST;
         armed_q <= 1'b0;
         start_q <= '0;
      end else begin
         xflag_q <= xf_nx;
         if (pm_wr) begin
            armed_q <= match;
            if (match) start_q <= tick;
         end else if (expire) begin
            armed_q <= 1'b0;
         end
      end
   end

   a_r7_request: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_wr && match) |=> (armed_q && !xflag_q[XF_RDY]));
   a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_wr && !match) |=> !armed_q);
   a_r8_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !pm_wr && !xf_wr && !(elapsed >= DLY)) |=> (armed_q && $stable(xflag_q)));
   a_r8_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(xflag_q[XF_RDY]) && !$past(xf_wr)) |-> !armed_q);
endmodule

// File: rtl/sfr_wfilter.sv
module sfr_wfilter
   import sfrf_pkg::*;
#(
   parameter int            AW     = 8,
   parameter int            TICK_W = 24,
   parameter int            DELAY  = 65535,
   parameter logic [AW-1:0] A_ACFG = 8'h40,
   parameter logic [AW-1:0] A_MCFG = 8'h41,
   parameter logic [AW-1:0] A_PSEL = 8'h42,
   parameter logic [AW-1:0] A_T2M  = 8'h43,
   parameter logic [AW-1:0] A_MCNT = 8'h44,
   parameter logic [AW-1:0] A_PMGT = 8'h45,
   parameter logic [AW-1:0] A_XFLG = 8'h46
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [TICK_W-1:0] tick,
   output logic [DW-1:0]     acfg_q,
   output logic [DW-1:0]     mcfg_q,
   output logic [DW-1:0]     psel_q,
   output logic [DW-1:0]     t2m_q,
   output logic [DW-1:0]     mcnt_q,
   output logic [DW-1:0]     pmgt_q,
   output logic [DW-1:0]     xflag_q,
   output logic              ready
);
   localparam logic [AW-1:0] MR_ADDR [NMR] = '{A_PSEL, A_T2M, A_MCNT, A_PMGT};
   localparam int            PM_IDX        = NMR - 1;
   localparam mreg_cfg_t     PM_CFG        = mreg_cfg(PM_IDX);

   if (AW < 2) begin : g_bad_aw
      $error("sfr_wfilter: address width too small");
   end

   logic [DW-1:0] mr_q [NMR];
   logic          pm_wr, xf_wr, armed;

   sfrf_lockout #(.AW(AW), .A_ACFG(A_ACFG), .A_MCFG(A_MCFG)) u_lock (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .acfg_q(acfg_q), .mcfg_q(mcfg_q));

   for (genvar i = 0; i < NMR; i++) begin : g_mreg
      localparam mreg_cfg_t C = mreg_cfg(i);
      sfrf_mreg #(.AW(AW), .ADDR(MR_ADDR[i]), .RSTV(C.rstv),
                  .ANDM(C.andm), .ORM(C.orm)) u_reg (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
         .wr_data(wr_data), .q(mr_q[i]));
   end

   assign psel_q = mr_q[0];
   assign t2m_q  = mr_q[1];
   assign mcnt_q = mr_q[2];
   assign pmgt_q = mr_q[PM_IDX];

   assign pm_wr = wr_en && (wr_addr == A_PMGT);
   assign xf_wr = wr_en && (wr_addr == A_XFLG);

   sfrf_warmup #(.TICK_W(TICK_W), .DELAY(DELAY)) u_warm (
      .clk(clk), .rst_n(rst_n), .pm_wr(pm_wr),
      .pm_val(filt(wr_data, PM_CFG.andm, PM_CFG.orm)),
      .xf_wr(xf_wr), .xf_data(wr_data), .tick(tick),
      .xflag_q(xflag_q), .armed_q(armed));

   assign ready = xflag_q[XF_RDY];

   a_r11_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_wr && armed) |=> (pmgt_q == $past(filt(wr_data, PM_CFG.andm, PM_CFG.orm))));
endmodule

// File: tb/sim_sfr_wfilter.sv
`timescale 1ns/1ps
module sim_sfr_wfilter;
   localparam int TW    = 24;
   localparam int DLY   = 65535;
   localparam logic [7:0] AC = 8'h40, MC = 8'h41, PS = 8'h42, TM = 8'h43,
                          MN = 8'h44, PM = 8'h45, XF = 8'h46;

   logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [7:0]    wr_addr = '0, wr_data = '0;
   logic [TW-1:0] tick = '0;
   logic [7:0]    acfg_q, mcfg_q, psel_q, t2m_q, mcnt_q, pmgt_q, xflag_q;
   logic          ready;

   int errors = 0, checks = 0;
   bit done = 0;

   // reference state
   logic [7:0]    m_ac, m_mc, m_ps, m_tm, m_mn, m_pm, m_xf;
   bit            m_arm;
   longint        m_st, tk;

   always #2.5 clk = ~clk;

   sfr_wfilter u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tick(tick), .acfg_q(acfg_q), .mcfg_q(mcfg_q),
      .psel_q(psel_q), .t2m_q(t2m_q), .mcnt_q(mcnt_q), .pmgt_q(pmgt_q),
      .xflag_q(xflag_q), .ready(ready));

   task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk8({tag, " acfg"}, acfg_q, m_ac);
      chk8({tag, " mcfg"}, mcfg_q, m_mc);
      chk8({tag, " psel"}, psel_q, m_ps);
      chk8({tag, " t2m"},  t2m_q,  m_tm);
      chk8({tag, " mcnt"}, mcnt_q, m_mn);
      chk8({tag, " pmgt"}, pmgt_q, m_pm);
      chk8({tag, " xflag"}, xflag_q, m_xf);
      chk8({tag, " ready"}, {7'd0, ready}, {7'd0, m_xf[3]});
   endtask

   task automatic model(input bit w, input logic [7:0] a, input logic [7:0] d);
      logic [7:0] n;
      bool_pm: begin end
      if (w) begin
         case (a)
            AC: begin n = d | 8'hF8; if (m_mc[7:6] == 2'b11) n[2] = 1'b0; m_ac = n; end
            MC: begin n = d | 8'h10; if (m_ac[2]) n[7:6] = 2'b00; m_mc = n; end
            PS: m_ps = (d & 8'hE5) | 8'h04;
            TM: m_tm = d | 8'hE0;
            MN: m_mn = d | 8'h0F;
            PM: begin
               m_pm = d | 8'h03;
               if ((m_pm & 8'hD0) == 8'h90) begin m_arm = 1; m_st = tk; m_xf[3] = 1'b0; end
               else m_arm = 0;
            end
            XF: m_xf = d;
            default: ;
         endcase
      end
      if (!(w && a == PM) && m_arm && (((tk - m_st) & ((64'd1 << TW) - 1)) >= DLY)) begin
         m_arm = 0;
         m_xf[3] = 1'b1;
      end
   endtask

   // one clock: drive, edge, model, compare at the falling edge
   task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d,
                       input longint dt, input string tag);
      wr_en = w; wr_addr = a; wr_data = d;
      tick = tk[TW-1:0];
      @(posedge clk);
      model(w, a, d);
      @(negedge clk);
      compare(tag);
      tk = (tk + dt) & ((64'd1 << TW) - 1);
   endtask

   initial begin
      m_ac = 8'hF8; m_mc = 8'h10; m_ps = 8'h04; m_tm = 8'hE4;
      m_mn = 8'h2F; m_pm = 8'h03; m_xf = 8'h00; m_arm = 0; m_st = 0; tk = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare("R1 reset");
      chk8("R1 acfg reset", acfg_q, 8'hF8);
      chk8("R1 t2m reset", t2m_q, 8'hE4);

      step(1, AC, 8'h00, 1, "R2");       chk8("R2 upper bits", acfg_q, 8'hF8);
      step(1, AC, 8'h07, 1, "R2");       chk8("R2 enable set", acfg_q, 8'hFF);
      step(1, MC, 8'hC0, 1, "R4");       chk8("R4 mode blocked", mcfg_q, 8'h10);
      step(1, AC, 8'h00, 1, "R2");
      step(1, MC, 8'hC5, 1, "R4");       chk8("R4 mode taken", mcfg_q, 8'hD5);
      step(1, AC, 8'h04, 1, "R3");       chk8("R3 enable blocked", acfg_q, 8'hF8);
      step(1, MC, 8'h00, 1, "R4");
      step(1, AC, 8'h04, 1, "R3");       chk8("R3 enable free", acfg_q, 8'hFC);
      step(1, PS, 8'hFF, 1, "R5");       chk8("R5 psel ff", psel_q, 8'hE5);
      step(1, PS, 8'h1A, 1, "R5");       chk8("R5 psel 1a", psel_q, 8'h04);
      step(1, TM, 8'h00, 1, "R6");       chk8("R6 t2m", t2m_q, 8'hE0);
      step(1, MN, 8'h30, 1, "R6");       chk8("R6 mcnt", mcnt_q, 8'h3F);
      step(1, PM, 8'h00, 1, "R6");       chk8("R6 pmgt", pmgt_q, 8'h03);
      step(1, XF, 8'hFF, 1, "R10");      chk8("R10 xflag plain", xflag_q, 8'hFF);
      step(1, 8'h7F, 8'h00, 1, "R10");   chk8("R10 unmapped", xflag_q, 8'hFF);
      step(0, XF, 8'h00, 1, "R10");      chk8("R10 no strobe", xflag_q, 8'hFF);

      // warm-up: exact boundary
      tk = 100;
      step(1, PM, 8'h90, 1, "R7");       chk8("R7 ready cleared", xflag_q, 8'hF7);
      for (int i = 0; i < 20; i++) step(0, 8'h00, 8'h00, 3000, "R8");
      tk = 100 + DLY - 1;
      step(0, 8'h00, 8'h00, 1, "R8");    chk8("R8 not early", {7'd0, ready}, 8'h00);
      step(0, 8'h00, 8'h00, 1, "R8");    chk8("R8 set on time", {7'd0, ready}, 8'h01);
      step(1, XF, 8'h00, 1, "R10");
      for (int i = 0; i < 10; i++) step(0, 8'h00, 8'h00, 20000, "R8");
      chk8("R8 one shot", xflag_q, 8'h00);

      // cancel
      step(1, PM, 8'hB4, 1, "R7");
      step(1, PM, 8'hD0, 1, "R9");
      for (int i = 0; i < 12; i++) step(0, 8'h00, 8'h00, 10000, "R9");
      chk8("R9 cancelled", {7'd0, ready}, 8'h00);

      // wrap of tick counter, with idle writes to other registers
      tk = (64'd1 << TW) - 10;
      step(1, PM, 8'h9C, 1, "R7");
      for (int i = 0; i < 40; i++) step(i % 3 == 0, MN, 8'(i), 2000, "R8");
      chk8("R8 across wrap", {7'd0, ready}, 8'h01);

      // rearm then a flag write in the expiry cycle keeps the ready bit set
      tk = 500;
      step(1, PM, 8'h90, 1, "R7");
      tk = 500 + DLY;
      step(1, XF, 8'h00, 1, "R11");      chk8("R11 ready over flag write", xflag_q, 8'h08);
      for (int i = 0; i < 3; i++) step(0, 8'h00, 8'h00, 1, "R11");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule